// File: doc/BRIEF.md
# Ownership-Arbitrated Host/Firmware Mailbox

This block carries one message in each direction between a host processor and an embedded controller that runs firmware. Each side reaches the block through its own small register port: an address, a write strobe with write data, and read data that follows the address combinationally. Before posting, a sender claims the mailbox through an owner register. Once the write is made, it reads the register back to confirm the claim. The transaction is over when the owner register returns to free.

Every message word holds an 8-bit type in bits 31:24 and a 24-bit payload in bits 23:0. The host writes the inbound word. The firmware writes the outbound word. Either side can read both words. A command register holds an interrupt enable and four route bits. From these bits the block drives level interrupts toward the firmware and toward three host-side destinations. A status register records a firmware event and a firmware-hang flag, and the host clears them by writing ones to them.

Register offsets on both ports: command 0xE4, inbound word 0xE8, outbound word 0xEC, owner 0xF0, status 0x428.

Top module: `mbox_core`

## Requirements
- R1: After reset the owner is free (0), the command, both message words and the status read 0, and all four interrupt outputs are low.
- R2: The owner codes are 0 for free, 1 for firmware and 2 for host. A port can claim the mailbox only by writing its own code while the owner is free, and a read shows the new owner in the next cycle. A claim while the mailbox is held has no effect, and so does a port writing the other port's code. If both ports claim in the same cycle, firmware wins.
- R3: Writing 0 to the owner from either port returns a held mailbox to free. The peer may release in this way to signal completion. A write of 3 has no effect.
- R4: Only the host port can change the inbound word (0xE8), and only the firmware port can change the outbound word (0xEC). A write from the other port has no effect. Both ports read both words in full, with the type in bits 31:24 and the payload in bits 23:0.
- R5: The command register keeps bits 31 (enable), 30 (host-controller route), 29 (SMI route), 28 (PME route) and 27 (firmware route), and its other bits read 0. If both ports write it in the same cycle, the firmware value is taken.
- R6: irq_fw is high exactly while command bits 31 and 27 are both set.
- R7: irq_pme is high while bits 31 and 28 are set. irq_hc is high while bits 31 and 30 are set.
- R8: Status bit 3 (event) is set when the firmware writes the command register with bits 31 and 29 both set. Status bit 1 (hang) is set when the firmware writes the status register with bit 1 set. A host write to status clears each bit written as 1. If a set and a clear arrive in the same cycle, the set wins.
- R9: irq_smi is high while command bits 31 and 29 are set and at least one of status bits 3 or 1 is set.
- R10: Reads of any other offset return 0, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_addr | input | ADDR_W | Host port register offset |
| h_wr | input | 1 | Host port write strobe |
| h_wdata | input | 32 | Host port write data |
| h_rdata | output | 32 | Host port read data for h_addr |
| f_addr | input | ADDR_W | Firmware port register offset |
| f_wr | input | 1 | Firmware port write strobe |
| f_wdata | input | 32 | Firmware port write data |
| f_rdata | output | 32 | Firmware port read data for f_addr |
| irq_fw | output | 1 | Interrupt toward the firmware CPU |
| irq_smi | output | 1 | SMI interrupt toward the host |
| irq_pme | output | 1 | PME interrupt toward the host |
| irq_hc | output | 1 | Interrupt toward the host controller |

## Verification
The owner register is tested in these cases:
- a lone host claim, then a claim by the other side while the mailbox is held;
- a release by the peer, a write of the invalid code 3, and claims from both ports in the same cycle.

Together these cases separate "claim only when free" from "last writer wins" and from "host has priority". Message words are written from the wrong port, so that a missing write-side filter shows up. The two ports also write the command register in the same cycle. The status bits are set and cleared together in one cycle, which separates set-wins from clear-wins. The SMI line is driven from the event bit alone and from the hang bit alone, which shows that both sources reach it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MSG_W  = 32;
    localparam int TYPE_W = 8;
    localparam int PLD_W  = MSG_W - TYPE_W;

    // command register bits kept, lowest kept bit position
    localparam int CMD_LSB = 27;
    localparam int CMD_W   = MSG_W - CMD_LSB;

    // indices inside the kept command field
    localparam int C_IE  = 4;
    localparam int C_HC  = 3;
    localparam int C_SMI = 2;
    localparam int C_PME = 1;
    localparam int C_FW  = 0;

    // status bit positions
    localparam int S_EVT  = 3;
    localparam int S_HANG = 1;

    typedef enum logic [1:0] {
        OWN_FREE = 2'd0,
        OWN_FW   = 2'd1,
        OWN_HOST = 2'd2
    } own_e;

    typedef struct packed {
        own_e             owner;
        logic [CMD_W-1:0] cmd;
        logic [MSG_W-1:0] din;
        logic [MSG_W-1:0] dout;
        logic             evt;
        logic             hang;
    } mbox_state_t;
endpackage

// File: rtl/mbox_owner_arb.sv
module mbox_owner_arb
    import mbox_pkg::*;
(
    input  own_e       cur,
    input  logic       h_own_wr,
    input  logic [1:0] h_val,
    input  logic       f_own_wr,
    input  logic [1:0] f_val,
    output own_e       nxt
);
    logic f_claim, h_claim, any_release;

    always_comb begin
        f_claim     = f_own_wr && (f_val == 2'(OWN_FW));
        h_claim     = h_own_wr && (h_val == 2'(OWN_HOST));
        any_release = (f_own_wr && (f_val == 2'(OWN_FREE))) ||
                      (h_own_wr && (h_val == 2'(OWN_FREE)));
        nxt = cur;
        if (cur == OWN_FREE) begin
            if (f_claim)      nxt = OWN_FW;
            else if (h_claim) nxt = OWN_HOST;
        end else if (any_release) begin
            nxt = OWN_FREE;
        end
    end
endmodule

// File: rtl/mbox_status.sv
module mbox_status
    import mbox_pkg::*;
(
    input  logic             evt_q,
    input  logic             hang_q,
    input  logic             f_cmd_wr,
    input  logic             f_stat_wr,
    input  logic [MSG_W-1:0] f_wdata,
    input  logic             h_stat_wr,
    input  logic [MSG_W-1:0] h_wdata,
    input  logic [CMD_W-1:0] cmd_q,
    output logic             evt_d,
    output logic             hang_d,
    output logic             irq_fw,
    output logic             irq_smi,
    output logic             irq_pme,
    output logic             irq_hc
);
    logic evt_set, hang_set, evt_clr, hang_clr;

    always_comb begin
        evt_set  = f_cmd_wr && f_wdata[CMD_LSB + C_IE] && f_wdata[CMD_LSB + C_SMI];
        hang_set = f_stat_wr && f_wdata[S_HANG];
        evt_clr  = h_stat_wr && h_wdata[S_EVT];
        hang_clr = h_stat_wr && h_wdata[S_HANG];
        evt_d    = evt_set  || (evt_q  && !evt_clr);
        hang_d   = hang_set || (hang_q && !hang_clr);

        irq_fw  = cmd_q[C_IE] && cmd_q[C_FW];
        irq_pme = cmd_q[C_IE] && cmd_q[C_PME];
        irq_hc  = cmd_q[C_IE] && cmd_q[C_HC];
        irq_smi = cmd_q[C_IE] && cmd_q[C_SMI] && (evt_q || hang_q);
    end
endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux
    import mbox_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CMD_OFS  = 'hE4,
    parameter int IN_OFS   = 'hE8,
    parameter int OUT_OFS  = 'hEC,
    parameter int OWN_OFS  = 'hF0,
    parameter int STAT_OFS = 'h428
) (
    input  logic [ADDR_W-1:0] addr,
    input  mbox_state_t       st,
    output logic [MSG_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CMD_OFS))       rdata = {st.cmd, {CMD_LSB{1'b0}}};
        else if (addr == ADDR_W'(IN_OFS))   rdata = st.din;
        else if (addr == ADDR_W'(OUT_OFS))  rdata = st.dout;
        else if (addr == ADDR_W'(OWN_OFS))  rdata = {{(MSG_W-2){1'b0}}, st.owner};
        else if (addr == ADDR_W'(STAT_OFS)) begin
            rdata[S_EVT]  = st.evt;
            rdata[S_HANG] = st.hang;
        end
    end
endmodule

// File: rtl/mbox_core.sv
module mbox_core
    import mbox_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CMD_OFS  = 'hE4,
    parameter int IN_OFS   = 'hE8,
    parameter int OUT_OFS  = 'hEC,
    parameter int OWN_OFS  = 'hF0,
    parameter int STAT_OFS = 'h428
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic              f_wr,
    input  logic [31:0]       f_wdata,
    output logic [31:0]       f_rdata,
    output logic              irq_fw,
    output logic              irq_smi,
    output logic              irq_pme,
    output logic              irq_hc
);
    localparam int NPORT = 2;

    mbox_state_t st_d, st_q;

    logic h_cmd_wr, h_in_wr, h_own_wr, h_stat_wr;
    logic f_cmd_wr, f_out_wr, f_own_wr, f_stat_wr;
    own_e own_d;
    logic evt_d, hang_d;

    // views of state for the bound checker
    logic [1:0]       own_q;
    logic [MSG_W-1:0] din_q, dout_q;
    logic             hang_q;

    always_comb begin
        h_cmd_wr  = h_wr && (h_addr == ADDR_W'(CMD_OFS));
        h_in_wr   = h_wr && (h_addr == ADDR_W'(IN_OFS));
        h_own_wr  = h_wr && (h_addr == ADDR_W'(OWN_OFS));
        h_stat_wr = h_wr && (h_addr == ADDR_W'(STAT_OFS));
        f_cmd_wr  = f_wr && (f_addr == ADDR_W'(CMD_OFS));
        f_out_wr  = f_wr && (f_addr == ADDR_W'(OUT_OFS));
        f_own_wr  = f_wr && (f_addr == ADDR_W'(OWN_OFS));
        f_stat_wr = f_wr && (f_addr == ADDR_W'(STAT_OFS));
    end

    mbox_owner_arb u_arb (
        .cur      (st_q.owner),
        .h_own_wr (h_own_wr),
        .h_val    (h_wdata[1:0]),
        .f_own_wr (f_own_wr),
        .f_val    (f_wdata[1:0]),
        .nxt      (own_d)
    );

    mbox_status u_stat (
        .evt_q     (st_q.evt),
        .hang_q    (st_q.hang),
        .f_cmd_wr  (f_cmd_wr),
        .f_stat_wr (f_stat_wr),
        .f_wdata   (f_wdata),
        .h_stat_wr (h_stat_wr),
        .h_wdata   (h_wdata),
        .cmd_q     (st_q.cmd),
        .evt_d     (evt_d),
        .hang_d    (hang_d),
        .irq_fw    (irq_fw),
        .irq_smi   (irq_smi),
        .irq_pme   (irq_pme),
        .irq_hc    (irq_hc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.owner = own_d;
        st_d.evt   = evt_d;
        st_d.hang  = hang_d;
        if (f_cmd_wr)      st_d.cmd = f_wdata[MSG_W-1:CMD_LSB];
        else if (h_cmd_wr) st_d.cmd = h_wdata[MSG_W-1:CMD_LSB];
        if (h_in_wr)  st_d.din  = h_wdata;
        if (f_out_wr) st_d.dout = f_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [ADDR_W-1:0] rd_addr [NPORT];
    logic [MSG_W-1:0]  rd_data [NPORT];

    assign rd_addr[0] = h_addr;
    assign rd_addr[1] = f_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        mbox_rdmux #(
            .ADDR_W  (ADDR_W),
            .CMD_OFS (CMD_OFS),
            .IN_OFS  (IN_OFS),
            .OUT_OFS (OUT_OFS),
            .OWN_OFS (OWN_OFS),
            .STAT_OFS(STAT_OFS)
        ) u_rd (
            .addr  (rd_addr[p]),
            .st    (st_q),
            .rdata (rd_data[p])
        );
    end

    assign h_rdata = rd_data[0];
    assign f_rdata = rd_data[1];

    assign own_q  = st_q.owner;
    assign din_q  = st_q.din;
    assign dout_q = st_q.dout;
    assign hang_q = st_q.hang;
endmodule

// File: rtl/mbox_core_chk.sv
module mbox_core_chk #(
    parameter int ADDR_W   = 12,
    parameter int STAT_OFS = 'h428
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_wr,
    input logic              f_wr,
    input logic [ADDR_W-1:0] h_addr,
    input logic [31:0]       h_wdata,
    input logic [1:0]        own_q,
    input logic [31:0]       din_q,
    input logic [31:0]       dout_q,
    input logic              hang_q,
    input logic [3:0]        irqs
);
    assert_free_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == 2'd0 && !h_wr && !f_wr) |=> (own_q == 2'd0));

    assert_fw_no_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == 2'd1) |=> (own_q != 2'd2));

    assert_host_no_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == 2'd2) |=> (own_q != 2'd1));

    assert_in_host_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !h_wr |=> $stable(din_q));

    assert_out_fw_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !f_wr |=> $stable(dout_q));

    assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_wr && !f_wr) |=> $stable(irqs));

    assert_hang_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hang_q && !(h_wr && h_addr == ADDR_W'(STAT_OFS) && h_wdata[1])) |=> hang_q);
endmodule

bind mbox_core mbox_core_chk #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_wr    (h_wr),
    .f_wr    (f_wr),
    .h_addr  (h_addr),
    .h_wdata (h_wdata),
    .own_q   (own_q),
    .din_q   (din_q),
    .dout_q  (dout_q),
    .hang_q  (hang_q),
    .irqs    ({irq_fw, irq_smi, irq_pme, irq_hc})
);

// File: tb/mbox_core_bench.sv
module mbox_core_bench;
    localparam int AW = 12;
    localparam logic [AW-1:0] A_CMD = 12'hE4, A_IN = 12'hE8, A_OUT = 12'hEC,
                              A_OWN = 12'hF0, A_STAT = 12'h428, A_NONE = 12'h100;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] h_addr = '0, f_addr = '0;
    logic h_wr = 0, f_wr = 0;
    logic [31:0] h_wdata = '0, f_wdata = '0;
    logic [31:0] h_rdata, f_rdata;
    logic irq_fw, irq_smi, irq_pme, irq_hc;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mbox_core u_mbox_core (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .f_addr(f_addr), .f_wr(f_wr), .f_wdata(f_wdata), .f_rdata(f_rdata),
        .irq_fw(irq_fw), .irq_smi(irq_smi), .irq_pme(irq_pme), .irq_hc(irq_hc)
    );

    // behavioural reference model
    int m_own, m_cmd, m_evt, m_hang;
    logic [31:0] m_din, m_dout;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_own = 0; m_cmd = 0; m_din = 0; m_dout = 0; m_evt = 0; m_hang = 0;
        end else begin
            int nown, nevt, nhang;
            nown = m_own;
            if (m_own == 0) begin
                if (f_wr && f_addr == A_OWN && f_wdata[1:0] == 2'd1) nown = 1;
                else if (h_wr && h_addr == A_OWN && h_wdata[1:0] == 2'd2) nown = 2;
            end else if ((f_wr && f_addr == A_OWN && f_wdata[1:0] == 0) ||
                         (h_wr && h_addr == A_OWN && h_wdata[1:0] == 0)) nown = 0;
            nevt = m_evt; nhang = m_hang;
            if (h_wr && h_addr == A_STAT && h_wdata[3]) nevt = 0;
            if (h_wr && h_addr == A_STAT && h_wdata[1]) nhang = 0;
            if (f_wr && f_addr == A_CMD && f_wdata[31] && f_wdata[29]) nevt = 1;
            if (f_wr && f_addr == A_STAT && f_wdata[1]) nhang = 1;
            if (f_wr && f_addr == A_CMD) m_cmd = int'(f_wdata[31:27]);
            else if (h_wr && h_addr == A_CMD) m_cmd = int'(h_wdata[31:27]);
            if (h_wr && h_addr == A_IN) m_din = h_wdata;
            if (f_wr && f_addr == A_OUT) m_dout = f_wdata;
            m_own = nown; m_evt = nevt; m_hang = nhang;
        end
    end

    function automatic logic [31:0] m_read(logic [AW-1:0] a);
        if (a == A_CMD)  return 32'(m_cmd) << 27;
        if (a == A_IN)   return m_din;
        if (a == A_OUT)  return m_dout;
        if (a == A_OWN)  return 32'(m_own);
        if (a == A_STAT) return 32'((m_evt << 3) | (m_hang << 1));
        return 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic ie;
            ie = (m_cmd >> 4) & 1;
            chk("R6 irq_fw", 32'(irq_fw), 32'(ie & (m_cmd & 1)));
            chk("R7 irq_pme", 32'(irq_pme), 32'(ie & ((m_cmd >> 1) & 1)));
            chk("R7 irq_hc", 32'(irq_hc), 32'(ie & ((m_cmd >> 3) & 1)));
            chk("R9 irq_smi", 32'(irq_smi),
                32'(ie & ((m_cmd >> 2) & 1) & ((m_evt | m_hang) != 0)));
            chk("R4 host read", h_rdata, m_read(h_addr));
            chk("R4 fw read", f_rdata, m_read(f_addr));
        end
    end

    task automatic hw(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1;
        @(negedge clk); h_wr = 0;
    endtask
    task automatic fw(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); f_addr = a; f_wdata = d; f_wr = 1;
        @(negedge clk); f_wr = 0;
    endtask
    task automatic bw(input logic [AW-1:0] ha, input logic [31:0] hd,
                      input logic [AW-1:0] fa, input logic [31:0] fd);
        @(negedge clk); h_addr = ha; h_wdata = hd; h_wr = 1;
        f_addr = fa; f_wdata = fd; f_wr = 1;
        @(negedge clk); h_wr = 0; f_wr = 0;
    endtask
    task automatic hr(input logic [AW-1:0] a, input string req, input logic [31:0] exp);
        @(negedge clk); h_addr = a; #1; chk(req, h_rdata, exp);
    endtask
    task automatic fr(input logic [AW-1:0] a, input string req, input logic [31:0] exp);
        @(negedge clk); f_addr = a; #1; chk(req, f_rdata, exp);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        hr(A_OWN, "R1 owner", 32'h0);
        hr(A_CMD, "R1 cmd", 32'h0);
        hr(A_STAT, "R1 status", 32'h0);
        chk("R1 irqs", 32'({irq_fw, irq_smi, irq_pme, irq_hc}), 32'h0);
        // R2 host claim, then firmware claim while held
        hw(A_OWN, 32'd2);
        hr(A_OWN, "R2 host claim", 32'd2);
        fw(A_OWN, 32'd1);
        fr(A_OWN, "R2 claim while held", 32'd2);
        // R3 peer release, invalid code
        fw(A_OWN, 32'd0);
        hr(A_OWN, "R3 peer release", 32'd0);
        hw(A_OWN, 32'd3);
        hr(A_OWN, "R3 code 3 ignored", 32'd0);
        hw(A_OWN, 32'd1);
        hr(A_OWN, "R2 foreign code ignored", 32'd0);
        // R2 simultaneous claim, firmware wins
        bw(A_OWN, 32'd2, A_OWN, 32'd1);
        hr(A_OWN, "R2 simultaneous claim", 32'd1);
        hw(A_OWN, 32'd0);
        // R4 message words
        hw(A_IN, 32'h12345678);
        fr(A_IN, "R4 inbound seen by fw", 32'h12345678);
        fw(A_IN, 32'hDEADBEEF);
        hr(A_IN, "R4 fw write to inbound ignored", 32'h12345678);
        fw(A_OUT, 32'h8000ABCD);
        hr(A_OUT, "R4 outbound word", 32'h8000ABCD);
        chk("R4 reply type field", 32'(h_rdata[31:24]), 32'h80);
        hw(A_OUT, 32'h81000000);
        hr(A_OUT, "R4 host write to outbound ignored", 32'h8000ABCD);
        // R5/R6 command
        hw(A_CMD, 32'hFFFFFFFF);
        hr(A_CMD, "R5 kept bits", 32'hF8000000);
        hw(A_CMD, 32'h88000000);
        #1 chk("R6 irq_fw set", 32'(irq_fw), 32'd1);
        hw(A_CMD, 32'h80000000);
        #1 chk("R6 irq_fw cleared", 32'(irq_fw), 32'd0);
        hw(A_CMD, 32'h08000000);
        #1 chk("R6 route without enable", 32'(irq_fw), 32'd0);
        // R7
        hw(A_CMD, 32'h90000000);
        #1 chk("R7 pme", 32'({irq_pme, irq_hc}), 32'b10);
        hw(A_CMD, 32'hC0000000);
        #1 chk("R7 hc", 32'({irq_pme, irq_hc}), 32'b01);
        bw(A_CMD, 32'h88000000, A_CMD, 32'h90000000);
        hr(A_CMD, "R5 simultaneous write fw wins", 32'h90000000);
        // R8/R9 event path
        fw(A_CMD, 32'hA0000000);
        hr(A_STAT, "R8 event set", 32'h8);
        chk("R9 smi on event", 32'(irq_smi), 32'd1);
        hw(A_CMD, 32'h80000000);
        #1 chk("R9 smi after route cleared", 32'(irq_smi), 32'd0);
        hw(A_STAT, 32'h8);
        hr(A_STAT, "R8 event cleared", 32'h0);
        hw(A_CMD, 32'hA0000000);
        #1 chk("R9 smi with no status", 32'(irq_smi), 32'd0);
        // hang path
        fw(A_STAT, 32'h2);
        hr(A_STAT, "R8 hang set", 32'h2);
        chk("R9 smi on hang", 32'(irq_smi), 32'd1);
        bw(A_STAT, 32'hA, A_STAT, 32'h2);
        hr(A_STAT, "R8 set wins over clear", 32'h2);
        hw(A_STAT, 32'h2);
        hr(A_STAT, "R8 hang cleared", 32'h0);
        chk("R9 smi dropped", 32'(irq_smi), 32'd0);
        // R10 unmapped
        hw(A_NONE, 32'hFFFFFFFF);
        fw(A_NONE, 32'hFFFFFFFF);
        hr(A_NONE, "R10 unmapped read", 32'h0);
        hr(A_CMD, "R10 cmd untouched", 32'hA0000000);
        fr(A_OUT, "R10 outbound untouched", 32'h8000ABCD);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule